// File: doc/BRIEF.md
# Serial Transmit Engine with Frame Options

This block turns bytes queued by a host into asynchronous serial frames on a single output line. Bytes enter a 16-entry first-in first-out buffer through a one-cycle write strobe. A serializer takes them out one at a time and sends a start bit, then 5 to 8 data bits in the chosen order, then an optional odd or even parity bit, then one or two stop bits. Bit timing comes only from an external baud tick: each tick ends the current bit and starts the next one.

The host sees a numeric state code, the buffer fill level and a ready flag. The host can raise a maskable completion interrupt when the buffer runs dry. Line polarity is chosen with an input. When inverted polarity is selected, every level on the line is flipped, including the idle level. An enable input freezes the whole block while it is low.

Top module: `serial_tx_engine`

## Requirements
- R1: After reset, state_o is 0, level_o is 0, ready_o is 1, irq_tx_o is 0, and tx_o sits at the idle level, which is 1 when active_low_i is 0.
- R2: The buffer holds 16 bytes and level_o reports 0 to 16. A write accepted while the level is 16 is discarded: the level stays at 16 and the byte is never sent.
- R3: A frame begins at the first enabled baud tick that finds state 0 and a non-empty buffer. Each later tick moves to the next bit. state_o reads 1 for the start bit, 2 for data bits, 3 for the parity bit and 4 for the stop bits. Before inversion the start bit is 0 and the stop bits are 1.
- R4: len_code_i selects the data bit count: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of the byte are sent.
- R5: With msb_first_i at 0 the data bits go out from bit 0 upward. With msb_first_i at 1 they go out from the highest used bit downward.
- R6: With par_en_i at 1, a parity bit follows the data. par_even_i at 1 makes the count of ones over the data and parity bits even; at 0 it makes that count odd. With par_en_i at 0, state 3 never appears.
- R7: two_stop_i at 0 sends one stop bit and at 1 sends two. Each stop bit lasts one tick interval.
- R8: With active_low_i at 1, tx_o is the inverse of the active-high level at all times, idle included.
- R9: ready_o is 1 exactly when state_o is 0.
- R10: An internal pending flag is set at the tick that ends the last stop bit if the buffer is then empty. The flag is cleared by an accepted write. irq_tx_o equals the pending flag ANDed with irq_tx_en_i.
- R11: While en_i is 0, write strobes and baud ticks have no effect on the buffer, the state or the line.
- R12: If the buffer is non-empty when the last stop bit ends, the next start bit follows at once with no idle interval.
- R13: The data length, stop count, parity and bit order are captured at the start bit. Changing these inputs in mid-frame does not alter the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Global enable; freezes the block when low |
| wr_i | input | 1 | Write strobe for one byte |
| wr_data_i | input | 8 | Byte to queue |
| baud_tick_i | input | 1 | One-cycle pulse that marks a bit boundary |
| len_code_i | input | 2 | Data length code (5 + code bits) |
| two_stop_i | input | 1 | 1 selects two stop bits |
| par_en_i | input | 1 | Enables the parity bit |
| par_even_i | input | 1 | 1 selects even parity, 0 selects odd |
| msb_first_i | input | 1 | 1 sends the most significant used bit first |
| active_low_i | input | 1 | 1 inverts every line level |
| irq_tx_en_i | input | 1 | Mask for the completion interrupt |
| tx_o | output | 1 | Serial output line |
| state_o | output | 3 | State code: 0 idle, 1 start, 2 data, 3 parity, 4 stop |
| level_o | output | 5 | Buffer occupancy, 0 to 16 |
| ready_o | output | 1 | 1 when idle, 0 while sending |
| irq_tx_o | output | 1 | Masked completion interrupt |

## Verification
The bench aims at the edges of the frame. Short 5-bit words sent MSB-first catch a design that indexes from bit 7 instead of the top used bit. Parity over a partial word catches a design that folds unused high bits into the parity and so sends a wrong bit. Two stop bits catch a design that ends after one. The bench also fills the buffer past 16 and then drains it back-to-back. A design that overwrites on a full buffer sends the 17th byte or shows a wrong level. A design that idles between queued frames shows state 0 where 1 is expected. Further tests flip the frame options in mid-frame, assert the interrupt only when the buffer is empty, check its mask and its clearing by a write, and freeze the block with the enable low. A latch-free design would shorten a frame in flight, and leaking ticks would start frames while disabled.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] len_code;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
    logic       msb_first;
  } frame_cfg_t;

endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [$clog2(DEPTH):0] level_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  // full check ignores a same-cycle pop: write to a full buffer is always dropped
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r2_level_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));

  a_r2_full_write_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (cnt_q == CNT_W'(DEPTH)));

endmodule

// File: rtl/stx_framer.sv
module stx_framer
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  frame_cfg_t        cfg_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] head_i,
  output logic              pop_o,
  output logic              done_o,
  output tx_state_e         state_o,
  output logic              line_o
);
  localparam int BIT_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  tx_state_e         state_q;
  frame_cfg_t        cfg_q;
  logic [DATA_W-1:0] word_q;
  logic [BIT_W-1:0]  cnt_q;
  logic              stop2_q;

  logic              adv, finishing, cur_bit, ones, par_bit;
  logic [BIT_W-1:0]  last_idx, sel_idx;
  logic [DATA_W-1:0] used_mask;

  assign adv       = en_i && tick_i;
  assign last_idx  = BIT_W'(MIN_BITS - 1) + BIT_W'(cfg_q.len_code);
  assign finishing = (state_q == ST_STOP) && (!cfg_q.two_stop || stop2_q);

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign used_mask[g] = (BIT_W'(g) <= last_idx);
  end

  assign sel_idx = cfg_q.msb_first ? (last_idx - cnt_q) : cnt_q;
  assign cur_bit = word_q[sel_idx];
  assign ones    = ^(word_q & used_mask);
  assign par_bit = cfg_q.par_even ? ones : ~ones;

  assign pop_o  = adv && avail_i && ((state_q == ST_IDLE) || finishing);
  assign done_o = adv && finishing;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      word_q  <= '0;
      cnt_q   <= '0;
      stop2_q <= 1'b0;
    end else if (adv) begin
      unique case (state_q)
        ST_IDLE: begin
          if (avail_i) begin
            state_q <= ST_START;
            word_q  <= head_i;
            cfg_q   <= cfg_i;
          end
        end
        ST_START: begin
          state_q <= ST_DATA;
          cnt_q   <= '0;
        end
        ST_DATA: begin
          if (cnt_q == last_idx) begin
            state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
            stop2_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          state_q <= ST_STOP;
          stop2_q <= 1'b0;
        end
        ST_STOP: begin
          if (!finishing) begin
            stop2_q <= 1'b1;
          end else if (avail_i) begin
            state_q <= ST_START;
            word_q  <= head_i;
            cfg_q   <= cfg_i;
            stop2_q <= 1'b0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = cur_bit;
      ST_PAR:   line_o = par_bit;
      default:  line_o = 1'b1;
    endcase
  end

  assign state_o = state_q;

  a_r3_moves_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && tick_i) |=> $stable(state_q));

  a_r3_data_index_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (cnt_q <= last_idx));

  a_r6_parity_only_if_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAR) |-> cfg_q.par_en);

  a_r7_second_stop_only_if_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP && stop2_q) |-> cfg_q.two_stop);

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine
  import stx_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              baud_tick_i,
  input  logic [1:0]        len_code_i,
  input  logic              two_stop_i,
  input  logic              par_en_i,
  input  logic              par_even_i,
  input  logic              msb_first_i,
  input  logic              active_low_i,
  input  logic              irq_tx_en_i,
  output logic              tx_o,
  output logic [2:0]        state_o,
  output logic [$clog2(DEPTH):0] level_o,
  output logic              ready_o,
  output logic              irq_tx_o
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  frame_cfg_t        cfg;
  logic [DATA_W-1:0] head;
  logic              full, empty, pop, done, line, wr_ok, pend_q;
  tx_state_e         state;
  logic [CNT_W-1:0]  level;

  assign cfg   = '{len_code: len_code_i, two_stop: two_stop_i, par_en: par_en_i,
                   par_even: par_even_i, msb_first: msb_first_i};
  assign wr_ok = wr_i && en_i && !full;

  stx_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_i && en_i),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .level_o     (level),
    .full_o      (full),
    .empty_o     (empty)
  );

  stx_framer #(.DATA_W(DATA_W)) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (baud_tick_i),
    .cfg_i   (cfg),
    .avail_i (!empty),
    .head_i  (head),
    .pop_o   (pop),
    .done_o  (done),
    .state_o (state),
    .line_o  (line)
  );

  // a write acknowledges; it wins over a same-cycle set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= 1'b0;
    else if (wr_ok)           pend_q <= 1'b0;
    else if (done && empty)   pend_q <= 1'b1;
  end

  assign tx_o     = line ^ active_low_i;
  assign state_o  = state;
  assign level_o  = level;
  assign ready_o  = (state == ST_IDLE);
  assign irq_tx_o = pend_q && irq_tx_en_i;

  a_r8_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (tx_o == !active_low_i));

  a_r10_pending_only_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (level == '0 && state == ST_IDLE));

  a_r11_frozen_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(level) && $stable(state)));

  a_r12_pop_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> (state == ST_START));

endmodule

// File: tb/serial_tx_engine_bench.sv
`timescale 1ns/1ps
module serial_tx_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1, wr = 1'b0, tick = 1'b0;
  logic [7:0] wdata = '0;
  logic [1:0] len_code = 2'd3;
  logic       two_stop = 1'b0, par_en = 1'b0, par_even = 1'b0, msb_first = 1'b0;
  logic       alow = 1'b0, irq_en = 1'b1;
  logic       tx, ready, irq;
  logic [2:0] state;
  logic [4:0] level;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  serial_tx_engine u_serial_tx_engine (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_i(wr), .wr_data_i(wdata),
    .baud_tick_i(tick), .len_code_i(len_code), .two_stop_i(two_stop),
    .par_en_i(par_en), .par_even_i(par_even), .msb_first_i(msb_first),
    .active_low_i(alow), .irq_tx_en_i(irq_en), .tx_o(tx), .state_o(state),
    .level_o(level), .ready_o(ready), .irq_tx_o(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  // precondition: state just entered 1; leaves it in the last stop bit
  task automatic expect_frame(input logic [7:0] d, input int code, input bit stop2,
                              input bit pen, input bit peven, input bit msb);
    int n = 5 + code;
    int ones = 0;
    chk("R3 start state", int'(state), 1);
    chk("R3 start level", int'(tx), int'(1'b0 ^ alow));
    chk("R9 busy", int'(ready), 0);
    for (int i = 0; i < n; i++) begin
      logic b;
      b = msb ? d[n-1-i] : d[i];
      ones += int'(d[i]);
      do_tick();
      chk("R3 data state", int'(state), 2);
      chk("R5 data bit", int'(tx), int'(b ^ alow));
    end
    if (pen) begin
      logic p;
      p = peven ? logic'(ones % 2) : !logic'(ones % 2);
      do_tick();
      chk("R6 parity state", int'(state), 3);
      chk("R6 parity bit", int'(tx), int'(p ^ alow));
    end
    for (int s = 0; s < (stop2 ? 2 : 1); s++) begin
      do_tick();
      chk("R7 stop state", int'(state), 4);
      chk("R7 stop level", int'(tx), int'(1'b1 ^ alow));
    end
  endtask

  task automatic set_cfg(input int code, input bit st2, input bit pen, input bit pev,
                         input bit msb, input bit al);
    @(negedge clk);
    len_code = 2'(code); two_stop = st2; par_en = pen; par_even = pev;
    msb_first = msb; alow = al;
  endtask

  task automatic single_frame(input logic [7:0] d, input int code, input bit st2,
                              input bit pen, input bit pev, input bit msb, input bit al);
    set_cfg(code, st2, pen, pev, msb, al);
    do_write(d);
    chk("R2 level after write", int'(level), 1);
    chk("R10 irq cleared by write", int'(irq), 0);
    do_tick();
    chk("R2 level after pop", int'(level), 0);
    expect_frame(d, code, st2, pen, pev, msb);
    chk("R10 no irq before end", int'(irq), 0);
    do_tick();
    chk("R3 back to idle", int'(state), 0);
    chk("R8 idle level", int'(tx), int'(!al));
    chk("R9 ready again", int'(ready), 1);
    chk("R10 irq at end", int'(irq), 1);
  endtask

  task automatic test_reset();
    chk("R1 state", int'(state), 0);
    chk("R1 level", int'(level), 0);
    chk("R1 ready", int'(ready), 1);
    chk("R1 irq", int'(irq), 0);
    chk("R1 tx idle", int'(tx), 1);
    do_tick();
    chk("R3 no frame when empty", int'(state), 0);
  endtask

  task automatic test_formats();
    single_frame(8'hA5, 3, 0, 0, 0, 0, 0);   // R4 8 bits, R5 lsb first
    single_frame(8'hF6, 0, 1, 1, 1, 1, 0);   // R4 5 bits msb first, R6 even, R7 two stop
    single_frame(8'h4B, 2, 0, 1, 0, 0, 1);   // R6 odd, R8 inverted
    single_frame(8'hD3, 1, 1, 1, 0, 1, 1);   // R4 6 bits
    single_frame(8'h81, 3, 0, 1, 1, 1, 0);
  endtask

  task automatic test_fill_drain();
    set_cfg(3, 0, 0, 0, 0, 0);
    for (int k = 0; k < 17; k++) do_write(8'(8'h10 + k));
    chk("R2 level capped", int'(level), 16);
    chk("R9 ready while queued", int'(ready), 1);
    do_tick();
    chk("R2 level after first pop", int'(level), 15);
    for (int k = 0; k < 16; k++) begin
      expect_frame(8'(8'h10 + k), 3, 0, 0, 0, 0);
      do_tick();
      if (k < 15) chk("R12 back-to-back start", int'(state), 1);
      else        chk("R2 extra byte not sent", int'(state), 0);
    end
    chk("R2 drained", int'(level), 0);
    chk("R10 irq after drain", int'(irq), 1);
  endtask

  task automatic test_irq_mask();
    @(negedge clk); irq_en = 1'b0;
    @(negedge clk);
    chk("R10 masked", int'(irq), 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R10 unmasked", int'(irq), 1);
    do_write(8'h5A);
    chk("R10 ack by write", int'(irq), 0);
    do_tick();
    expect_frame(8'h5A, 3, 0, 0, 0, 0);
    do_tick();
    chk("R10 set again", int'(irq), 1);
  endtask

  task automatic test_enable();
    @(negedge clk); en = 1'b0;
    do_write(8'h33);
    chk("R11 write ignored", int'(level), 0);
    chk("R11 irq kept", int'(irq), 1);
    @(negedge clk); en = 1'b1;
    do_write(8'h33);
    chk("R11 write accepted", int'(level), 1);
    @(negedge clk); en = 1'b0;
    do_tick(); do_tick();
    chk("R11 tick ignored state", int'(state), 0);
    chk("R11 tick ignored level", int'(level), 1);
    chk("R11 line idle", int'(tx), 1);
    @(negedge clk); en = 1'b1;
    do_tick();
    expect_frame(8'h33, 3, 0, 0, 0, 0);
    do_tick();
    chk("R11 frame completes", int'(state), 0);
  endtask

  task automatic test_latch();
    set_cfg(3, 0, 0, 0, 0, 0);
    do_write(8'hC9);
    do_tick();
    @(negedge clk);
    len_code = 2'd0; par_en = 1'b1; two_stop = 1'b1; msb_first = 1'b1;
    expect_frame(8'hC9, 3, 0, 0, 0, 0);   // R13 old settings kept
    do_tick();
    chk("R13 frame not lengthened", int'(state), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_formats();
    test_fill_drain();
    test_irq_mask();
    test_enable();
    test_latch();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule